// File: doc/BRIEF.md
# Two-Wide Operand Bypass Network

This block picks the value fed to each of the four ALU inputs of a two-lane in-order pipeline: two operand inputs per lane. For every ALU input it compares the source register number against the destination register numbers of the four in-flight producers: both lanes in the memory stage and both lanes in the writeback stage. When a match is found, it forwards that producer's result in place of the register-file read value.

The block is purely combinational. A selected operand appears in the same cycle as the specifiers and data that produced it.

Selection is worked out once per ALU input, from the register-number compares, as a one-hot choice. Every data bit then uses that choice through an identical one-bit AND-OR slice. The slice is repeated across the parameterised data width.

When several producers match, the newest value wins:
- A memory-stage result beats a writeback-stage result.
- Within one stage, the second (younger) lane beats the first.

Register zero, and any producer that is not writing, are never forwarded.

Top module: `bypass_net2`

## Requirements
- R1: When no producer matches an ALU input's source register, that input receives its own register-file read value.
- R2: A matching memory-stage producer is forwarded in preference to any matching writeback-stage producer.
- R3: When no memory-stage producer matches, a matching writeback-stage producer is forwarded instead of the register-file value.
- R4: When both memory-stage lanes write the requested register, the lane-1 (younger) result is forwarded.
- R5: When both writeback-stage lanes write the requested register and no memory-stage lane matches, the lane-1 result is forwarded.
- R6: A source register number of 0 always receives the register-file value, even when producers carry destination 0 with their write enable high.
- R7: A producer whose write enable is low is never forwarded, whatever its destination register number.
- R8: The four ALU inputs are resolved independently, so in one cycle each may take a different source. Operand index 2*lane+k is input k of that lane.
- R9: Every bit of a forwarded operand comes from the same selected source, across the full data width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_spec | input | 4x5 | Source register number per ALU input, index 2*lane+k |
| rf_data | input | 4xDATA_W | Register-file read value per ALU input |
| mem_wen | input | 2 | Memory-stage write enable per lane |
| mem_rd | input | 2x5 | Memory-stage destination register per lane |
| mem_data | input | 2xDATA_W | Memory-stage result per lane |
| wb_wen | input | 2 | Writeback-stage write enable per lane |
| wb_rd | input | 2x5 | Writeback-stage destination register per lane |
| wb_data | input | 2xDATA_W | Writeback-stage result per lane |
| opnd | output | 4xDATA_W | Selected operand per ALU input |

## Verification
The assertions assume that all inputs hold known values whenever they are evaluated. They also assume that a producer's destination number is meaningful only while its write enable is high.

The stimulus drives every input, including all data words and unused specifiers, at time zero and before each change. Enables stay low except where a scenario needs a producer. Data words in each scenario are distinct per source, so any wrong selection shows up as a value mismatch.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  localparam int unsigned REG_W = 5;
  localparam int unsigned LANES = 2;
  localparam int unsigned OPS_PER_LANE = 2;
endpackage

// File: rtl/bypass_sel_ctrl.sv
module bypass_sel_ctrl #(
  parameter int unsigned LANES = 2,
  parameter int unsigned REG_W = 5,
  localparam int unsigned NSRC = 2 * LANES + 1
) (
  input  logic [REG_W-1:0]            spec,
  input  logic [LANES-1:0]            mem_wen,
  input  logic [LANES-1:0][REG_W-1:0] mem_rd,
  input  logic [LANES-1:0]            wb_wen,
  input  logic [LANES-1:0][REG_W-1:0] wb_rd,
  output logic [NSRC-1:0]             sel
);
  // hit order = priority order: memory stage youngest first, then writeback
  logic [NSRC-2:0] hit;

  for (genvar j = 0; j < LANES; j++) begin : g_cmp
    assign hit[j] = mem_wen[LANES-1-j] && (mem_rd[LANES-1-j] != '0)
                    && (mem_rd[LANES-1-j] == spec);
    assign hit[LANES+j] = wb_wen[LANES-1-j] && (wb_rd[LANES-1-j] != '0)
                          && (wb_rd[LANES-1-j] == spec);
  end

  always_comb begin
    logic taken;
    sel   = '0;
    taken = 1'b0;
    for (int k = 0; k < NSRC - 1; k++) begin
      if (hit[k] && !taken) begin
        sel[k] = 1'b1;
        taken  = 1'b1;
      end
    end
    if (!taken) sel[NSRC-1] = 1'b1;
  end

  always_comb begin
    // R6: source zero never matches any producer
    if (spec == '0) a_r6_zero_no_hit: assert (hit == '0);
    // R7: a disabled memory-stage lane never raises its compare
    for (int l = 0; l < LANES; l++)
      if (!mem_wen[l]) a_r7_mem_disabled: assert (!hit[LANES-1-l]);
  end
endmodule

// File: rtl/bypass_bit_slice.sv
module bypass_bit_slice #(
  parameter int unsigned NSRC = 5
) (
  input  logic [NSRC-1:0] sel,
  input  logic [NSRC-1:0] din,
  output logic            dout
);
  assign dout = |(sel & din);
endmodule

// File: rtl/bypass_operand_mux.sv
module bypass_operand_mux #(
  parameter int unsigned NSRC   = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic [NSRC-1:0]             sel,
  input  logic [NSRC-1:0][DATA_W-1:0] cand,
  output logic [DATA_W-1:0]           dout
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic [NSRC-1:0] col;
    for (genvar s = 0; s < NSRC; s++) begin : g_col
      assign col[s] = cand[s][b];
    end
    bypass_bit_slice #(.NSRC(NSRC)) u_slice (
      .sel (sel),
      .din (col),
      .dout(dout[b])
    );
  end
endmodule

// File: rtl/bypass_net2.sv
module bypass_net2
  import bypass_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NOPS = LANES * OPS_PER_LANE,
  localparam int unsigned NSRC = 2 * LANES + 1
) (
  input  logic [NOPS-1:0][REG_W-1:0]   op_spec,
  input  logic [NOPS-1:0][DATA_W-1:0]  rf_data,
  input  logic [LANES-1:0]             mem_wen,
  input  logic [LANES-1:0][REG_W-1:0]  mem_rd,
  input  logic [LANES-1:0][DATA_W-1:0] mem_data,
  input  logic [LANES-1:0]             wb_wen,
  input  logic [LANES-1:0][REG_W-1:0]  wb_rd,
  input  logic [LANES-1:0][DATA_W-1:0] wb_data,
  output logic [NOPS-1:0][DATA_W-1:0]  opnd
);
  for (genvar o = 0; o < NOPS; o++) begin : g_op
    logic [NSRC-1:0]             sel;
    logic [NSRC-1:0][DATA_W-1:0] cand;

    for (genvar j = 0; j < LANES; j++) begin : g_cand
      assign cand[j]       = mem_data[LANES-1-j];
      assign cand[LANES+j] = wb_data[LANES-1-j];
    end
    assign cand[NSRC-1] = rf_data[o];

    bypass_sel_ctrl #(.LANES(LANES), .REG_W(REG_W)) u_ctrl (
      .spec   (op_spec[o]),
      .mem_wen(mem_wen),
      .mem_rd (mem_rd),
      .wb_wen (wb_wen),
      .wb_rd  (wb_rd),
      .sel    (sel)
    );

    bypass_operand_mux #(.NSRC(NSRC), .DATA_W(DATA_W)) u_mux (
      .sel (sel),
      .cand(cand),
      .dout(opnd[o])
    );

    always_comb begin
      logic mem_any, any;
      mem_any = 1'b0;
      any     = 1'b0;
      for (int l = 0; l < LANES; l++) begin
        if (mem_wen[l] && mem_rd[l] == op_spec[o]) mem_any = 1'b1;
        if (wb_wen[l] && wb_rd[l] == op_spec[o]) any = 1'b1;
      end
      any = any || mem_any;
      if (op_spec[o] == '0 || !any)
        a_r1_rf_default: assert (opnd[o] == rf_data[o]);
      if (op_spec[o] != '0 && mem_wen[LANES-1] && mem_rd[LANES-1] == op_spec[o])
        a_r4_young_mx: assert (opnd[o] == mem_data[LANES-1]);
      if (op_spec[o] != '0 && !mem_any && wb_wen[LANES-1] && wb_rd[LANES-1] == op_spec[o])
        a_r5_young_wx: assert (opnd[o] == wb_data[LANES-1]);
    end
  end
endmodule

// File: tb/bypass_net2_tb.sv
module bypass_net2_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0][4:0]    op_spec;
  logic [3:0][DW-1:0] rf_data;
  logic [1:0]         mem_wen, wb_wen;
  logic [1:0][4:0]    mem_rd, wb_rd;
  logic [1:0][DW-1:0] mem_data, wb_data;
  logic [3:0][DW-1:0] opnd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bypass_net2 #(.DATA_W(DW)) u_dut (
    .op_spec(op_spec), .rf_data(rf_data),
    .mem_wen(mem_wen), .mem_rd(mem_rd), .mem_data(mem_data),
    .wb_wen(wb_wen), .wb_rd(wb_rd), .wb_data(wb_data),
    .opnd(opnd)
  );

  task automatic chk(input int o, input logic [DW-1:0] exp, input string req);
    checks++;
    if (opnd[o] !== exp) begin
      errors++;
      $display("FAIL %s operand %0d actual %h expected %h", req, o, opnd[o], exp);
    end
  endtask

  task automatic clear();
    op_spec = '0;
    mem_wen = '0; wb_wen = '0;
    mem_rd = '0; wb_rd = '0;
    for (int o = 0; o < 4; o++) rf_data[o] = 32'hA000_0000 + o;
    mem_data[0] = 32'hB000_0000; mem_data[1] = 32'hB000_0001;
    wb_data[0]  = 32'hC000_0000; wb_data[1]  = 32'hC000_0001;
  endtask

  task automatic t_idle();
    @(posedge clk); clear();
    op_spec[0] = 3; op_spec[1] = 17; op_spec[2] = 31; op_spec[3] = 1;
    mem_rd[0] = 3; wb_rd[1] = 17;
    @(negedge clk);
    for (int o = 0; o < 4; o++) chk(o, 32'hA000_0000 + o, "R1");
  endtask

  task automatic t_mx_wx();
    @(posedge clk); clear();
    mem_wen = 2'b01; mem_rd[0] = 5;
    wb_wen = 2'b11; wb_rd[1] = 5; wb_rd[0] = 7;
    op_spec[0] = 5; op_spec[1] = 7;
    @(negedge clk);
    chk(0, 32'hB000_0000, "R2");
    chk(1, 32'hC000_0000, "R3");
    chk(2, 32'hA000_0002, "R1");
  endtask

  task automatic t_young_mx();
    @(posedge clk); clear();
    mem_wen = 2'b11; mem_rd[0] = 9; mem_rd[1] = 9;
    wb_wen = 2'b11; wb_rd[0] = 9; wb_rd[1] = 9;
    op_spec[3] = 9;
    @(negedge clk);
    chk(3, 32'hB000_0001, "R4");
  endtask

  task automatic t_young_wx();
    @(posedge clk); clear();
    wb_wen = 2'b11; wb_rd[0] = 12; wb_rd[1] = 12;
    mem_wen = 2'b00; mem_rd[0] = 12; mem_rd[1] = 12;
    op_spec[2] = 12;
    @(negedge clk);
    chk(2, 32'hC000_0001, "R5");
  endtask

  task automatic t_zero();
    @(posedge clk); clear();
    mem_wen = 2'b11; wb_wen = 2'b11;
    @(negedge clk);
    for (int o = 0; o < 4; o++) chk(o, 32'hA000_0000 + o, "R6");
  endtask

  task automatic t_wen_low();
    @(posedge clk); clear();
    mem_rd[0] = 4; mem_rd[1] = 4; wb_rd[0] = 4; wb_rd[1] = 4;
    op_spec[1] = 4;
    @(negedge clk);
    chk(1, 32'hA000_0001, "R7");
    @(posedge clk); wb_wen = 2'b01;
    @(negedge clk);
    chk(1, 32'hC000_0000, "R7");
  endtask

  task automatic t_mixed();
    @(posedge clk); clear();
    mem_wen = 2'b11; mem_rd[0] = 2; mem_rd[1] = 6;
    wb_wen = 2'b11; wb_rd[0] = 8; wb_rd[1] = 10;
    op_spec[0] = 10; op_spec[1] = 2; op_spec[2] = 8; op_spec[3] = 6;
    @(negedge clk);
    chk(0, 32'hC000_0001, "R8");
    chk(1, 32'hB000_0000, "R8");
    chk(2, 32'hC000_0000, "R8");
    chk(3, 32'hB000_0001, "R8");
  endtask

  task automatic t_bits();
    @(posedge clk); clear();
    mem_data[0] = 32'h5555_5555; mem_data[1] = 32'hAAAA_AAAA;
    wb_data[0] = 32'hFFFF_0000; wb_data[1] = 32'h0000_FFFF;
    rf_data[3] = 32'h8000_0001;
    mem_wen = 2'b11; mem_rd[0] = 20; mem_rd[1] = 21;
    wb_wen = 2'b11; wb_rd[0] = 22; wb_rd[1] = 23;
    op_spec[0] = 20; op_spec[1] = 21; op_spec[2] = 23; op_spec[3] = 30;
    @(negedge clk);
    chk(0, 32'h5555_5555, "R9");
    chk(1, 32'hAAAA_AAAA, "R9");
    chk(2, 32'h0000_FFFF, "R9");
    chk(3, 32'h8000_0001, "R9");
  endtask

  initial begin
    clear();
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int o = 0; o < 4; o++) chk(o, 32'hA000_0000 + o, "R1");
    t_idle();
    t_mx_wx();
    t_young_mx();
    t_young_wx();
    t_zero();
    t_wen_low();
    t_mixed();
    t_bits();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 10000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule